// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of sixteen general-purpose pins reached over a simple 16-bit register bus. Software uses it for three jobs. It drives output data, output enables and alternate-function selects toward the pad ring. It reads back the synchronised pin levels. It turns pin activity into latched interrupt flags. Every register holds one bit per pin.

Each pin brings its input through a synchroniser. A trigger-type bit chooses how the pin raises an interrupt. In edge mode the pin reacts to a rising or a falling edge. In level mode it reacts to a high or a low level. An edge-polarity bit and a level-polarity bit, each in its own register, pick the direction.

A detection on a pin whose interrupt-mask bit is clear sets that pin's status bit. The bank drives one summary interrupt line, which is the OR of all status bits. Software clears the status bits by writing to the status register. A second mask, the sleep mask, decides which pins may raise the registered wake-up request. Detection of both edges is left to software, which flips the edge polarity after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the interrupt-mask and sleep-mask registers read 0xFFFF. Output data, direction, alternate-function, trigger-type, edge-polarity, level-polarity and status read 0. pin_out, pin_oe, alt_sel, irq_out and wake_req are all low.
- R2: Each read/write register reads back the value last written. The registers and their addresses are: output data (0x0), direction (0x1), alternate function (0x2), interrupt mask (0x3), sleep mask (0x4), trigger type (0x5), edge polarity (0x6) and level polarity (0x7). Output data drives pin_out, direction drives pin_oe (1 = output) and alternate function drives alt_sel.
- R3: Reading address 0x8 returns the synchronised pin levels. A pin change first shows there at the second rising clock edge after it.
- R4: With trigger type 1 and edge polarity 1, a rising edge sets the pin's status bit (address 0x9). The bit is visible after the third clock edge following the pin change. A falling edge sets nothing.
- R5: With trigger type 1 and edge polarity 0, a falling edge sets the status bit and a rising edge does not.
- R6: With trigger type 0, level polarity 1 makes a high level active and 0 makes a low level active. While the active level persists, the status bit cannot be cleared: it stays set through a clear write.
- R7: A detection on a pin whose interrupt-mask bit is 1 sets no status bit. If the pin is unmasked while its level condition still holds, the status bit is set one cycle after the mask write.
- R8: A write to the status register keeps only the bits written as 1, so writing zero clears them all. A detection in the same cycle as the write still sets its bit.
- R9: irq_out is high exactly when at least one status bit is set.
- R10: wake_req is raised one cycle after a detection on a pin whose sleep-mask bit is 0, whatever that pin's interrupt mask is. Pins with sleep-mask bit 1 never raise it.
- R11: Writes to the pin-level address 0x8 have no effect. Addresses 0xA to 0xF read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data toward the pads |
| pin_oe | output | 16 | Output enable per pin (1 = output) |
| alt_sel | output | 16 | Alternate-function select per pin |
| irq_out | output | 1 | Summary interrupt (OR of status bits) |
| wake_req | output | 1 | Wake-up request from non-excluded pins |

## Verification
A status-clear write and a new detection can land on the same clock edge. The clear must drop the older flags, while the new event's flag must survive. The bench first latches one pin's flag. It then makes a second pin change so that its detection reaches the status register on the same edge as a write of zero. The result is judged by reading the status register: the old bit must be gone and the new bit present. A held level condition against a clear write is judged the same way, and there the bit must survive the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_ADDR_W = 4;

    typedef logic [BUS_ADDR_W-1:0] reg_addr_t;

    // register map of the bank
    localparam reg_addr_t ADDR_DOUT   = 4'h0;
    localparam reg_addr_t ADDR_DIR    = 4'h1;
    localparam reg_addr_t ADDR_ALT    = 4'h2;
    localparam reg_addr_t ADDR_IMASK  = 4'h3;
    localparam reg_addr_t ADDR_SMASK  = 4'h4;
    localparam reg_addr_t ADDR_TTYPE  = 4'h5;
    localparam reg_addr_t ADDR_EPOL   = 4'h6;
    localparam reg_addr_t ADDR_LPOL   = 4'h7;
    localparam reg_addr_t ADDR_PINLVL = 4'h8;
    localparam reg_addr_t ADDR_STAT   = 4'h9;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int NPINS  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] prev
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][NPINS-1:0] stage_d, stage_q;
    logic [NPINS-1:0]             prev_d, prev_q;

    // first stage takes the raw pins, every later stage takes its neighbour
    assign stage_d[0] = pin_in;
    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_chain
            assign stage_d[s] = stage_q[s-1];
        end
    endgenerate

    always_comb begin
        prev_d = stage_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            stage_q <= stage_d;
            prev_q  <= prev_d;
        end
    end

    assign level = stage_q[LAST];
    assign prev  = prev_q;

endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
    parameter int NPINS = 16
) (
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] prev,
    input  logic [NPINS-1:0] ttype,
    input  logic [NPINS-1:0] epol,
    input  logic [NPINS-1:0] lpol,
    output logic [NPINS-1:0] hit
);

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            logic rise_w;
            logic fall_w;
            logic edge_hit_w;
            logic lvl_hit_w;

            assign rise_w     = level[p] & ~prev[p];
            assign fall_w     = ~level[p] & prev[p];
            assign edge_hit_w = epol[p] ? rise_w : fall_w;
            assign lvl_hit_w  = lpol[p] ? level[p] : ~level[p];
            assign hit[p]     = ttype[p] ? edge_hit_w : lvl_hit_w;
        end
    endgenerate

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  reg_addr_t        bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] dout,
    output logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] alt,
    output logic [NPINS-1:0] imask,
    output logic [NPINS-1:0] smask,
    output logic [NPINS-1:0] ttype,
    output logic [NPINS-1:0] epol,
    output logic [NPINS-1:0] lpol,
    output logic [NPINS-1:0] status,
    output logic             wake
);

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] alt;
        logic [NPINS-1:0] imask;
        logic [NPINS-1:0] smask;
        logic [NPINS-1:0] ttype;
        logic [NPINS-1:0] epol;
        logic [NPINS-1:0] lpol;
        logic [NPINS-1:0] status;
        logic             wake;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            unique case (bus_addr)
                ADDR_DOUT:  st_d.dout   = bus_wdata;
                ADDR_DIR:   st_d.dir    = bus_wdata;
                ADDR_ALT:   st_d.alt    = bus_wdata;
                ADDR_IMASK: st_d.imask  = bus_wdata;
                ADDR_SMASK: st_d.smask  = bus_wdata;
                ADDR_TTYPE: st_d.ttype  = bus_wdata;
                ADDR_EPOL:  st_d.epol   = bus_wdata;
                ADDR_LPOL:  st_d.lpol   = bus_wdata;
                ADDR_STAT:  st_d.status = st_q.status & bus_wdata;
                default:    ;
            endcase
        end
        // a fresh detection outranks a clear landing on the same edge
        st_d.status = st_d.status | (hit & ~st_q.imask);
        st_d.wake   = |(hit & ~st_q.smask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.imask <= '1;
            st_q.smask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DOUT:   bus_rdata = st_q.dout;
            ADDR_DIR:    bus_rdata = st_q.dir;
            ADDR_ALT:    bus_rdata = st_q.alt;
            ADDR_IMASK:  bus_rdata = st_q.imask;
            ADDR_SMASK:  bus_rdata = st_q.smask;
            ADDR_TTYPE:  bus_rdata = st_q.ttype;
            ADDR_EPOL:   bus_rdata = st_q.epol;
            ADDR_LPOL:   bus_rdata = st_q.lpol;
            ADDR_PINLVL: bus_rdata = pin_level;
            ADDR_STAT:   bus_rdata = st_q.status;
            default:     bus_rdata = '0;
        endcase
    end

    assign dout   = st_q.dout;
    assign dir    = st_q.dir;
    assign alt    = st_q.alt;
    assign imask  = st_q.imask;
    assign smask  = st_q.smask;
    assign ttype  = st_q.ttype;
    assign epol   = st_q.epol;
    assign lpol   = st_q.lpol;
    assign status = st_q.status;
    assign wake   = st_q.wake;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] alt_sel,
    output logic             irq_out,
    output logic             wake_req
);

    logic [NPINS-1:0] level_w, prev_w, hit_w;
    logic [NPINS-1:0] imask_w, smask_w, ttype_w, epol_w, lpol_w, status_w;
    logic             wake_w;

    gpio_bank_sync #(
        .NPINS  (NPINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level_w),
        .prev   (prev_w)
    );

    gpio_bank_detect #(
        .NPINS (NPINS)
    ) i_detect (
        .level (level_w),
        .prev  (prev_w),
        .ttype (ttype_w),
        .epol  (epol_w),
        .lpol  (lpol_w),
        .hit   (hit_w)
    );

    gpio_bank_regs #(
        .NPINS (NPINS)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_level (level_w),
        .hit       (hit_w),
        .dout      (pin_out),
        .dir       (pin_oe),
        .alt       (alt_sel),
        .imask     (imask_w),
        .smask     (smask_w),
        .ttype     (ttype_w),
        .epol      (epol_w),
        .lpol      (lpol_w),
        .status    (status_w),
        .wake      (wake_w)
    );

    assign irq_out  = |status_w;
    assign wake_req = wake_w;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] imask,
    input logic [NPINS-1:0] smask,
    input logic [NPINS-1:0] status,
    input logic             irq_out,
    input logic             wake_req
);

    assert_no_set_without_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));

    assert_masked_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & $past(imask)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit & ~imask) & ~status) == '0));

    assert_clear_keeps_only_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_STAT)
        |=> ((status & ~$past(bus_wdata) & ~$past(hit & ~imask)) == '0));

    assert_irq_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|(hit & ~imask)));

    assert_wake_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(|(hit & ~smask)));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hit       (hit_w),
    .imask     (imask_w),
    .smask     (smask_w),
    .status    (status_w),
    .irq_out   (irq_out),
    .wake_req  (wake_req)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [15:0] pins = 16'h0;
    logic [15:0] pin_out, pin_oe, alt_sel;
    logic        irq_out, wake_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pins),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .alt_sel   (alt_sel),
        .irq_out   (irq_out),
        .wake_req  (wake_req)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic [15:0] wval;
        logic [15:0] expv;
    } vec_t;

    // write-then-read vectors (R2, R11)
    localparam vec_t VECS [10] = '{
        '{4'h0, 16'hA5A5, 16'hA5A5},
        '{4'h1, 16'h00FF, 16'h00FF},
        '{4'h2, 16'h1234, 16'h1234},
        '{4'h3, 16'h0F0F, 16'h0F0F},
        '{4'h4, 16'hFFFF, 16'hFFFF},
        '{4'h5, 16'h8001, 16'h8001},
        '{4'h6, 16'h0002, 16'h0002},
        '{4'h7, 16'h4000, 16'h4000},
        '{4'h8, 16'hFFFF, 16'h0000},
        '{4'hF, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, expv);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setpins(input logic [15:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic chk_stat(input string tag, input logic [15:0] expv);
        logic [15:0] v;
        rd(4'h9, v);
        chk(tag, v, expv);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        rd(4'h3, v); chk("R1 imask", v, 16'hFFFF);
        rd(4'h4, v); chk("R1 smask", v, 16'hFFFF);
        rd(4'h1, v); chk("R1 dir", v, 16'h0000);
        rd(4'h5, v); chk("R1 ttype", v, 16'h0000);
        chk_stat("R1 status", 16'h0000);
        chk("R1 outputs", {pin_oe | pin_out | alt_sel}, 16'h0000);
        chk("R1 irq/wake", {14'h0, irq_out, wake_req}, 16'h0000);

        // R2 / R11 table walk
        for (int i = 0; i < 10; i++) begin
            wr(VECS[i].addr, VECS[i].wval);
            rd(VECS[i].addr, v);
            chk($sformatf("R2/R11 vec%0d", i), v, VECS[i].expv);
        end
        chk("R2 pin_out", pin_out, 16'hA5A5);
        chk("R2 pin_oe", pin_oe, 16'h00FF);
        chk("R2 alt_sel", alt_sel, 16'h1234);

        // interrupt configuration
        wr(4'h3, 16'hFFFF);
        wr(4'h5, 16'h0003);
        wr(4'h6, 16'h0001);
        wr(4'h7, 16'h0004);
        wr(4'h9, 16'h0000);
        chk_stat("R8 write zero clears", 16'h0000);

        // R3 pin level latency
        setpins(16'h00F0);
        wait_n(1);
        rd(4'h8, v); chk("R3 one edge", v, 16'h0000);
        wait_n(1);
        rd(4'h8, v); chk("R3 two edges", v, 16'h00F0);
        wr(4'h8, 16'h0000);
        rd(4'h8, v); chk("R11 pin level write ignored", v, 16'h00F0);

        setpins(16'h0008);
        wait_n(3);
        wr(4'h3, 16'hFFF0);
        wait_n(1);
        chk_stat("R7 unmask idle", 16'h0000);

        // R4 rising edge
        setpins(16'h0009);
        wait_n(2);
        chk_stat("R4 not yet", 16'h0000);
        wait_n(1);
        chk_stat("R4 rising", 16'h0001);
        chk("R9 irq high", {15'h0, irq_out}, 16'h0001);
        wr(4'h9, 16'h0000);
        chk_stat("R8 clear", 16'h0000);
        chk("R9 irq low", {15'h0, irq_out}, 16'h0000);
        setpins(16'h0008);
        wait_n(4);
        chk_stat("R4 falling ignored", 16'h0000);

        // R5 falling edge
        setpins(16'h000A);
        wait_n(4);
        chk_stat("R5 rising ignored", 16'h0000);
        setpins(16'h0008);
        wait_n(3);
        chk_stat("R5 falling", 16'h0002);
        wr(4'h9, 16'h0000);

        // R6 level high and low
        setpins(16'h000C);
        wait_n(3);
        chk_stat("R6 level high", 16'h0004);
        wr(4'h9, 16'h0000);
        chk_stat("R6 persists through clear", 16'h0004);
        setpins(16'h0008);
        wait_n(3);
        wr(4'h9, 16'h0000);
        chk_stat("R6 cleared after release", 16'h0000);
        setpins(16'h0000);
        wait_n(3);
        chk_stat("R6 level low", 16'h0008);
        setpins(16'h0008);
        wait_n(3);
        wr(4'h9, 16'h0000);

        // R7 mask
        wr(4'h3, 16'hFFF4);
        setpins(16'h000C);
        wait_n(4);
        chk_stat("R7 masked", 16'h0000);
        chk("R7 irq masked", {15'h0, irq_out}, 16'h0000);
        wr(4'h3, 16'hFFF0);
        wait_n(1);
        chk_stat("R7 unmask sets", 16'h0004);
        setpins(16'h0008);
        wait_n(3);
        wr(4'h9, 16'h0000);
        chk_stat("R7 cleanup", 16'h0000);

        // R8 keep-ones and same-cycle set/clear
        setpins(16'h000A);
        wait_n(3);
        setpins(16'h0008);
        wait_n(3);
        chk_stat("R8 setup", 16'h0002);
        wr(4'h9, 16'h0002);
        chk_stat("R8 one keeps", 16'h0002);
        setpins(16'h0009);
        wait_n(1);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = 4'h9;
        bus_wdata = 16'h0000;
        @(negedge clk);
        bus_wr = 1'b0;
        chk_stat("R8 set wins over clear", 16'h0001);
        wr(4'h9, 16'h0000);

        // R10 wake
        wr(4'h3, 16'hFFFF);
        wr(4'h4, 16'hFFFE);
        setpins(16'h0008);
        wait_n(4);
        chk("R10 idle", {15'h0, wake_req}, 16'h0000);
        setpins(16'h0009);
        wait_n(2);
        chk("R10 not yet", {15'h0, wake_req}, 16'h0000);
        wait_n(1);
        chk("R10 wake", {15'h0, wake_req}, 16'h0001);
        chk_stat("R10 masked status", 16'h0000);
        wait_n(1);
        chk("R10 one cycle", {15'h0, wake_req}, 16'h0000);
        wr(4'h4, 16'hFFFF);
        setpins(16'h0008);
        wait_n(4);
        setpins(16'h0009);
        wait_n(3);
        chk("R10 excluded", {15'h0, wake_req}, 16'h0000);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule